// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the controller of a processor datapath that runs each instruction over several clock cycles, with one shared memory for code and data and one ALU. It is a Moore machine: a state register and combinational logic that produce, from the state alone, the enables and selects the datapath needs in that cycle. The logic also picks the next state from the 6-bit opcode field of the instruction register. The only exceptions are the ALU function code, which is also decoded from the funct field, and the PC enable, which combines the conditional PC write with the datapath's zero flag.

Every instruction starts with two common steps. The first fetches the word into the instruction register and advances the PC. The second reads both source registers and computes the branch target. After that the sequence splits by class. Register-to-register operations take four cycles. Loads take five, stores four, and branches and jumps three each. An opcode the block does not recognise returns to fetch straight after decode.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While reset (`rst_n` low) is held and in the first cycle after it is released, the outputs show the fetch step: `mem_rd`=1, `addr_sel`=0, `ir_wr`=1, `pc_wr`=1, `pc_en`=1, `alu_b_sel`=1 (constant 4), `pc_src`=0.
- R2: In every step, an output not named for that step is 0. The decode step asserts no write and no memory enable. In decode, `alu_a_sel`=0 (PC), `alu_b_sel`=3 (offset shifted by 2) and `alu_op`=0 (add).
- R3: A register operation (opcode 0x00) takes 4 cycles. Its execute step has `alu_a_sel`=1, `alu_b_sel`=0 and `alu_op`=2 (by funct). Its write step has `reg_wr`=1, `dst_sel`=1 (rd) and `wb_sel`=0 (ALU output register).
- R4: A load (opcode 0x23) takes 5 cycles. The address step has `alu_a_sel`=1 and `alu_b_sel`=2 (sign-extended offset). The read step has `mem_rd`=1 and `addr_sel`=1. The write step has `reg_wr`=1, `dst_sel`=0 (rt) and `wb_sel`=1 (memory data register).
- R5: A store (opcode 0x2b) takes 4 cycles. It shares the load's address step and ends with `mem_wr`=1 and `addr_sel`=1.
- R6: A branch-if-equal (opcode 0x04) takes 3 cycles. Its last step has `alu_a_sel`=1, `alu_b_sel`=0, `alu_op`=1 (subtract), `pc_wr_cond`=1 and `pc_src`=1. `pc_en` is 1 in that step only when `alu_zero` is 1.
- R7: A jump (opcode 0x02) takes 3 cycles. Its last step has `pc_wr`=1, `pc_en`=1 and `pc_src`=2.
- R8: Any other opcode takes 2 cycles, fetch and decode only, with no write of any kind.
- R9: `alu_ctl` is 3'b010 for `alu_op` 0, 3'b110 for `alu_op` 1, and for `alu_op` 2 follows funct: 0x20→010, 0x22→110, 0x24→000, 0x25→001, 0x2a→111, anything else→010.
- R10: `mem_rd` and `mem_wr` are never 1 together, and every final step is followed by a fetch step.
- R11: The sequence load, load, branch not taken, add, store takes 21 cycles from the first fetch to the next fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opcode | input | 6 | Opcode field of the instruction register |
| funct | input | 6 | Function field of the instruction register |
| alu_zero | input | 1 | ALU result is zero |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU output register |
| ir_wr | output | 1 | Load instruction register |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write if operands equal |
| pc_en | output | 1 | Effective PC load enable |
| reg_wr | output | 1 | Register file write |
| dst_sel | output | 1 | Destination: 0 rt, 1 rd |
| wb_sel | output | 1 | Write data: 0 ALU output register, 1 memory data register |
| alu_a_sel | output | 1 | ALU A: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B: 0 B, 1 constant 4, 2 offset, 3 offset shifted by 2 |
| alu_op | output | 2 | ALU class: 0 add, 1 subtract, 2 by funct |
| alu_ctl | output | 3 | ALU function code |
| pc_src | output | 2 | PC source: 0 ALU result, 1 ALU output register, 2 jump target |

## Verification
The bench builds the block with its default opcode and funct codes, so all five classes and the five function encodings can be reached. It steps through every instruction one cycle at a time and compares the full control word with the value it expects for that step. This also catches any step that is too long or too short. Random instruction mixes with random funct fields and zero flags cover branch taken and not taken and the unknown-funct fallback. Directed cases cover reset, an unknown opcode and the 21-cycle five-instruction sequence.

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm #(
  parameter int OP_W = 6,
  parameter int FN_W = 6,
  parameter logic [OP_W-1:0] OP_ALU = 6'h00,
  parameter logic [OP_W-1:0] OP_LD  = 6'h23,
  parameter logic [OP_W-1:0] OP_ST  = 6'h2b,
  parameter logic [OP_W-1:0] OP_BEQ = 6'h04,
  parameter logic [OP_W-1:0] OP_JMP = 6'h02,
  parameter logic [FN_W-1:0] FN_ADD = 6'h20,
  parameter logic [FN_W-1:0] FN_SUB = 6'h22,
  parameter logic [FN_W-1:0] FN_AND = 6'h24,
  parameter logic [FN_W-1:0] FN_OR  = 6'h25,
  parameter logic [FN_W-1:0] FN_SLT = 6'h2a
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] opcode,
  input  logic [FN_W-1:0] funct,
  input  logic            alu_zero,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            addr_sel,
  output logic            ir_wr,
  output logic            pc_wr,
  output logic            pc_wr_cond,
  output logic            pc_en,
  output logic            reg_wr,
  output logic            dst_sel,
  output logic            wb_sel,
  output logic            alu_a_sel,
  output logic [1:0]      alu_b_sel,
  output logic [1:0]      alu_op,
  output logic [2:0]      alu_ctl,
  output logic [1:0]      pc_src
);

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_ADDR, S_LDMEM, S_LDWB,
    S_STMEM, S_EXEC, S_RWB, S_BRANCH, S_JUMP
  } step_t;

  localparam logic [1:0] OPC_ADD = 2'd0;
  localparam logic [1:0] OPC_SUB = 2'd1;
  localparam logic [1:0] OPC_FN  = 2'd2;

  step_t cur, nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) cur <= S_FETCH;
    else        cur <= nxt;
  end

  always_comb begin
    nxt = S_FETCH;
    case (cur)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: begin
        if      (opcode == OP_ALU)                     nxt = S_EXEC;
        else if (opcode == OP_LD || opcode == OP_ST)   nxt = S_ADDR;
        else if (opcode == OP_BEQ)                     nxt = S_BRANCH;
        else if (opcode == OP_JMP)                     nxt = S_JUMP;
        else                                           nxt = S_FETCH;
      end
      S_ADDR:   nxt = (opcode == OP_LD) ? S_LDMEM : S_STMEM;
      S_LDMEM:  nxt = S_LDWB;
      S_EXEC:   nxt = S_RWB;
      default:  nxt = S_FETCH;
    endcase
  end

  always_comb begin
    mem_rd = 1'b0; mem_wr = 1'b0; addr_sel = 1'b0; ir_wr = 1'b0;
    pc_wr = 1'b0; pc_wr_cond = 1'b0; reg_wr = 1'b0; dst_sel = 1'b0;
    wb_sel = 1'b0; alu_a_sel = 1'b0; alu_b_sel = 2'd0; alu_op = OPC_ADD;
    pc_src = 2'd0;
    case (cur)
      S_FETCH: begin
        mem_rd = 1'b1; ir_wr = 1'b1; pc_wr = 1'b1; alu_b_sel = 2'd1;
      end
      S_DECODE: alu_b_sel = 2'd3;
      S_ADDR: begin
        alu_a_sel = 1'b1; alu_b_sel = 2'd2;
      end
      S_LDMEM: begin
        mem_rd = 1'b1; addr_sel = 1'b1;
      end
      S_LDWB: begin
        reg_wr = 1'b1; wb_sel = 1'b1;
      end
      S_STMEM: begin
        mem_wr = 1'b1; addr_sel = 1'b1;
      end
      S_EXEC: begin
        alu_a_sel = 1'b1; alu_op = OPC_FN;
      end
      S_RWB: begin
        reg_wr = 1'b1; dst_sel = 1'b1;
      end
      S_BRANCH: begin
        alu_a_sel = 1'b1; alu_op = OPC_SUB; pc_wr_cond = 1'b1; pc_src = 2'd1;
      end
      S_JUMP: begin
        pc_wr = 1'b1; pc_src = 2'd2;
      end
      default: ;
    endcase
  end

  assign pc_en = pc_wr | (pc_wr_cond & alu_zero);

  always_comb begin
    case (alu_op)
      OPC_SUB: alu_ctl = 3'b110;
      OPC_FN: begin
        if      (funct == FN_ADD) alu_ctl = 3'b010;
        else if (funct == FN_SUB) alu_ctl = 3'b110;
        else if (funct == FN_AND) alu_ctl = 3'b000;
        else if (funct == FN_OR)  alu_ctl = 3'b001;
        else if (funct == FN_SLT) alu_ctl = 3'b111;
        else                      alu_ctl = 3'b010;
      end
      default: alu_ctl = 3'b010;
    endcase
  end

  // R10
  mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R2
  decode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ir_wr |=> !(ir_wr || pc_wr || pc_wr_cond || reg_wr || mem_rd || mem_wr));

  // R6
  branch_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr_cond |=> ir_wr);

  // R5
  store_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> ir_wr);

  // R4
  load_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && addr_sel) |=> (reg_wr && wb_sel && !dst_sel));

  // R3
  rtype_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op == OPC_FN) |=> (reg_wr && dst_sel && !wb_sel));

  // R10
  wb_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> ir_wr);

endmodule

// File: tb/test_mc_ctrl_fsm.sv
module test_mc_ctrl_fsm;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] opcode = 6'h00, funct = 6'h00;
  logic alu_zero = 1'b0;
  logic mem_rd, mem_wr, addr_sel, ir_wr, pc_wr, pc_wr_cond, pc_en;
  logic reg_wr, dst_sel, wb_sel, alu_a_sel;
  logic [1:0] alu_b_sel, alu_op, pc_src;
  logic [2:0] alu_ctl;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  mc_ctrl_fsm i_mc_ctrl_fsm (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .funct(funct), .alu_zero(alu_zero),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel), .ir_wr(ir_wr),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_en(pc_en), .reg_wr(reg_wr),
    .dst_sel(dst_sel), .wb_sel(wb_sel), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .alu_op(alu_op), .alu_ctl(alu_ctl), .pc_src(pc_src)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // classes: 0 reg op, 1 load, 2 store, 3 branch, 4 jump, 5 unknown
  function automatic logic [5:0] op_of(int cls);
    case (cls)
      0: return 6'h00; 1: return 6'h23; 2: return 6'h2b;
      3: return 6'h04; 4: return 6'h02; default: return 6'h3f;
    endcase
  endfunction

  function automatic int len_of(int cls);
    case (cls)
      0: return 4; 1: return 5; 2: return 4; 3: return 3; 4: return 3;
      default: return 2;
    endcase
  endfunction

  // R9
  function automatic logic [2:0] ctl_of(logic [1:0] op, logic [5:0] fn);
    if (op == 2'd1) return 3'b110;
    if (op != 2'd2) return 3'b010;
    case (fn)
      6'h20: return 3'b010; 6'h22: return 3'b110; 6'h24: return 3'b000;
      6'h25: return 3'b001; 6'h2a: return 3'b111; default: return 3'b010;
    endcase
  endfunction

  // {mem_rd,mem_wr,addr_sel,ir_wr,pc_wr,pc_wr_cond,pc_en,reg_wr,dst_sel,wb_sel,a,b[2],op[2],ctl[3],src[2]}
  function automatic logic [19:0] expect_word(int cls, int st, logic [5:0] fn, logic z);
    logic mr, mw, as, iw, pw, pc, rw, ds, ws, aa;
    logic [1:0] bs, op, ps;
    {mr, mw, as, iw, pw, pc, rw, ds, ws, aa} = '0;
    bs = 2'd0; op = 2'd0; ps = 2'd0;
    if (st == 0) begin mr = 1; iw = 1; pw = 1; bs = 2'd1; end
    else if (st == 1) bs = 2'd3;
    else case (cls)
      0: if (st == 2) begin aa = 1; op = 2'd2; end else begin rw = 1; ds = 1; end
      1, 2: if (st == 2) begin aa = 1; bs = 2'd2; end
            else if (cls == 2) begin mw = 1; as = 1; end
            else if (st == 3) begin mr = 1; as = 1; end
            else begin rw = 1; ws = 1; end
      3: begin aa = 1; op = 2'd1; pc = 1; ps = 2'd1; end
      4: begin pw = 1; ps = 2'd2; end
      default: ;
    endcase
    return {mr, mw, as, iw, pw, pc, pw | (pc & z), rw, ds, ws, aa, bs, op, ctl_of(op, fn), ps};
  endfunction

  function automatic logic [19:0] actual_word();
    return {mem_rd, mem_wr, addr_sel, ir_wr, pc_wr, pc_wr_cond, pc_en, reg_wr,
            dst_sel, wb_sel, alu_a_sel, alu_b_sel, alu_op, alu_ctl, pc_src};
  endfunction

  function automatic string req_of(int cls);
    case (cls)
      0: return "R3"; 1: return "R4"; 2: return "R5"; 3: return "R6";
      4: return "R7"; default: return "R8";
    endcase
  endfunction

  task automatic check(string req, logic [19:0] act, logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // starts and ends just after a negative edge
  task automatic run_instr(int cls, logic [5:0] fn, logic z);
    for (int s = 0; s < len_of(cls); s++) begin
      opcode = op_of(cls); funct = fn; alu_zero = z;
      #1;
      check((s == 0) ? "R10" : (s == 1) ? "R2" : req_of(cls), actual_word(),
            expect_word(cls, s, fn, z));
      if (cls == 0 && s == 2) check("R9", {17'd0, alu_ctl}, {17'd0, ctl_of(2'd2, fn)});
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [5:0] fns [6];
    int start;
    fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24;
    fns[3] = 6'h25; fns[4] = 6'h2a; fns[5] = 6'h11;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1 check("R1", actual_word(), expect_word(0, 0, 6'h00, 1'b0));
    @(negedge clk);
    rst_n = 1'b1;
    #1 check("R1", actual_word(), expect_word(0, 0, 6'h00, 1'b0));
    #1;
    for (int k = 0; k < 6; k++) run_instr(0, fns[k], 1'b0);
    run_instr(3, 6'h00, 1'b1);
    run_instr(3, 6'h00, 1'b0);
    run_instr(4, 6'h00, 1'b0);
    run_instr(5, 6'h00, 1'b0);
    run_instr(1, 6'h00, 1'b1);
    run_instr(2, 6'h00, 1'b1);
    // R11
    start = cyc;
    run_instr(1, 6'h00, 1'b0);
    run_instr(1, 6'h00, 1'b0);
    run_instr(3, 6'h00, 1'b0);
    run_instr(0, 6'h20, 1'b0);
    run_instr(2, 6'h00, 1'b0);
    #1;
    check("R11", {19'd0, ir_wr}, 20'd1);
    check("R11", 20'(cyc - start), 20'd21);
    for (int n = 0; n < 300; n++) begin
      int cls = int'($urandom_range(0, 5));
      logic [5:0] fn = ($urandom_range(0, 3) == 0) ? 6'($urandom) : fns[$urandom_range(0, 4)];
      run_instr(cls, fn, 1'($urandom));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule